// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block turns on three switching regulators in a fixed order after a global enable input goes high. The three regulators are rail 0 (buck A), rail 1 (buck B) and rail 2 (buck-boost). A two-bit order code selects one of three bring-up orders. The code comes from an external detector that decodes a pin with three input levels. The block holds a rail's enable until that rail's power-good flag is steady, and only then enables the next rail in the order. If the flag never arrives, a programmable cycle timeout moves the sequence on.

Each rail also has its own register enable bit. A set bit turns the rail on with or without the sequence. Each power-good flag passes through a synchronizer and a debounce filter before the sequencer or the all-good output uses it. The all-good output reports that every rail currently enabled has settled. Rails that are off do not count toward it.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, every rail enable output is low and `all_good` is low.
- R2: With order code 2'b00 latched, the rails are enabled in the order rail 0, rail 1, rail 2.
- R3: With order code 2'b01 latched, the rails are enabled in the order rail 0, rail 2, rail 1.
- R4: With order code 2'b10 latched, the order is rail 2, rail 0, rail 1. Code 2'b11 behaves as 2'b00.
- R5: During the sequence, the next rail is enabled only after the current rail's filtered power-good is high. Each step adds at most one rail.
- R6: If the current rail's power-good does not arrive, the next rail is enabled exactly `tmo_lim` cycles after the current one.
- R7: The order code is captured in the cycle the sequence starts. Later changes to it have no effect until the next start.
- R8: When `en_all` falls, every rail whose register bit is clear goes low in the same cycle. The next rise of `en_all` restarts the sequence from its first rail.
- R9: A set bit in `reg_en` drives the matching rail enable high whatever the state of `en_all`.
- R10: `all_good` is high only when at least one rail is enabled, no sequence is in progress, and every enabled rail's filtered power-good is high. With no rail enabled, it is low.
- R11: `all_good` is low in every cycle in which a sequence is in progress, even if all enabled rails are good.
- R12: A power-good change takes effect only after the synchronized level has held for `DEB_LEN` cycles. A rise is seen `SYNC_STAGES+DEB_LEN` cycles after it reaches the pin. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_all | input | 1 | Global sequenced enable, active high |
| order_sel | input | 2 | Decoded order code (00, 01, 10; 11 as 00) |
| reg_en | input | 3 | Per-rail register enable bits |
| pg_raw | input | 3 | Unsynchronized per-rail power-good flags |
| tmo_lim | input | TMO_W | Step timeout in cycles |
| rail_en | output | 3 | Per-rail enable lines |
| all_good | output | 1 | All enabled rails settled |

## Verification
The bench models each regulator as a responder that raises its power-good a set number of cycles after its enable rises. It records the cycle in which each enable first rises. Every order code, including the unused one, is run with equal delays, and the recorded cycles show which order the sequencer picked. A run with one responder that never answers shows the timeout path is separate from the power-good path, and it checks the exact step length. Runs that change the order code during a sequence, combine register enables with the sequence, or pulse a power-good flag briefly show latching, override behaviour and debounce. Each of these can be told apart from a design that only gets the common case right.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   localparam int NRAIL = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      ORD_LOW   = 2'b00,
      ORD_HIGH  = 2'b01,
      ORD_FLOAT = 2'b10,
      ORD_RSVD  = 2'b11
   } ord_sel_t;

   // rail index: 0 = buck A, 1 = buck B, 2 = buck-boost
   function automatic logic [1:0] rail_at(input logic [1:0] sel, input logic [1:0] step);
      logic [1:0] r;
      case (sel)
         ORD_HIGH: begin
            case (step)
               2'd0:    r = 2'd0;
               2'd1:    r = 2'd2;
               default: r = 2'd1;
            endcase
         end
         ORD_FLOAT: begin
            case (step)
               2'd0:    r = 2'd2;
               2'd1:    r = 2'd0;
               default: r = 2'd1;
            endcase
         end
         default: begin
            case (step)
               2'd0:    r = 2'd0;
               2'd1:    r = 2'd1;
               default: r = 2'd2;
            endcase
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rail_pg_filter.sv
module rail_pg_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_LEN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_in,
   output logic pg_clean
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rail_pg_filter: SYNC_STAGES must be at least 2");
   end
   if (DEB_LEN < 1) begin : g_bad_deb
      $error("rail_pg_filter: DEB_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_sr;
   logic                   pg_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sr <= '0;
      else        sync_sr <= {sync_sr[SYNC_STAGES-2:0], pg_in};
   end

   assign pg_sync = sync_sr[SYNC_STAGES-1];

   if (DEB_LEN == 1) begin : g_nodeb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pg_clean <= 1'b0;
         else        pg_clean <= pg_sync;
      end
   end else begin : g_deb
      localparam int CW = $clog2(DEB_LEN);
      localparam logic [CW-1:0] CMAX = CW'(DEB_LEN - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt      <= '0;
            pg_clean <= 1'b0;
         end else if (pg_sync == pg_clean) begin
            cnt <= '0;
         end else if (cnt == CMAX) begin
            cnt      <= '0;
            pg_clean <= pg_sync;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R12: the filtered level only ever moves to the synchronized level
   p_clean_follows_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pg_clean) |-> (pg_clean == $past(pg_sync)));

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
   import rail_seq_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_all,
   input  logic [1:0]       order_sel,
   input  logic [NRAIL-1:0] pg_ok,
   input  logic [TMO_W-1:0] tmo_lim,
   output logic [NRAIL-1:0] seq_mask,
   output logic             busy
);

   localparam logic [1:0] LAST_STEP = 2'(NRAIL - 1);

   seq_state_t       state;
   logic [1:0]       step;
   logic [1:0]       sel_q;
   logic [TMO_W-1:0] timer;
   logic [1:0]       cur_rail;
   logic             tmo_hit;
   logic             advance;

   assign cur_rail = rail_at(sel_q, step);
   assign tmo_hit  = ({1'b0, timer} + (TMO_W+1)'(1)) >= {1'b0, tmo_lim};
   assign advance  = pg_ok[cur_rail] || tmo_hit;
   assign busy     = (state == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         step  <= '0;
         sel_q <= '0;
         timer <= '0;
      end else if (!en_all) begin
         state <= SEQ_IDLE;
         step  <= '0;
         timer <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               state <= SEQ_RUN;
               sel_q <= order_sel;
               step  <= '0;
               timer <= '0;
            end
            SEQ_RUN: begin
               if (advance) begin
                  timer <= '0;
                  if (step == LAST_STEP) state <= SEQ_DONE;
                  else                   step  <= step + 1'b1;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            default: begin
               state <= SEQ_DONE;
               timer <= '0;
            end
         endcase
      end
   end

   always_comb begin
      seq_mask = '0;
      case (state)
         SEQ_RUN: begin
            for (int k = 0; k < NRAIL; k++) begin
               if (2'(k) <= step) seq_mask[rail_at(sel_q, 2'(k))] = 1'b1;
            end
         end
         SEQ_DONE: seq_mask = '1;
         default:  seq_mask = '0;
      endcase
   end

   // R7: the captured order code holds while the sequence runs
   p_sel_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_RUN && $past(state) == SEQ_RUN) |-> (sel_q == $past(sel_q)));

   // R5: at most one rail is added per cycle
   p_grow_one_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_all && $past(en_all)) |-> ($countones(seq_mask) <= $countones($past(seq_mask)) + 1));

   // R8: a low global enable returns the sequencer to idle
   p_idle_after_drop_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_all |=> (state == SEQ_IDLE));

   // R6: the step timer only runs inside a sequence
   p_timer_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_RUN) |-> (timer == '0));

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
   import rail_seq_pkg::*;
#(
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_LEN     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_all,
   input  logic [1:0]       order_sel,
   input  logic [2:0]       reg_en,
   input  logic [2:0]       pg_raw,
   input  logic [TMO_W-1:0] tmo_lim,
   output logic [2:0]       rail_en,
   output logic             all_good
);

   if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
      $error("rail_seq_top: TMO_W out of range");
   end

   logic [NRAIL-1:0] pg_ok;
   logic [NRAIL-1:0] seq_mask;
   logic             busy;

   for (genvar i = 0; i < NRAIL; i++) begin : g_rail
      rail_pg_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .DEB_LEN     (DEB_LEN)
      ) u_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .pg_in    (pg_raw[i]),
         .pg_clean (pg_ok[i])
      );
   end

   rail_seq_fsm #(
      .TMO_W (TMO_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_all    (en_all),
      .order_sel (order_sel),
      .pg_ok     (pg_ok),
      .tmo_lim   (tmo_lim),
      .seq_mask  (seq_mask),
      .busy      (busy)
   );

   assign rail_en  = (seq_mask & {NRAIL{en_all}}) | reg_en;
   assign all_good = !busy && (|rail_en) && ((rail_en & ~pg_ok) == '0);

   // R11: the cycle after a start is always inside the sequence
   p_good_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_all) |=> !all_good);

   // R9: a register bit always holds its rail on
   p_reg_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_en & reg_en) == reg_en));

endmodule

// File: tb/rail_seq_top_tb_top.sv
module rail_seq_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int DEB        = 4;
   localparam int NEVER      = 1000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_all = 1'b0;
   logic [1:0]  order_sel = 2'b00;
   logic [2:0]  reg_en = 3'b000;
   logic [2:0]  pg_raw;
   logic [2:0]  glitch = 3'b000;
   logic [15:0] tmo_lim = 16'd1000;
   logic [2:0]  rail_en;
   logic        all_good;

   int dly[3];
   int cnt[3];
   int t_on[3];
   logic [2:0] prev_en = 3'b000;
   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_seq_top #(.TMO_W(16), .SYNC_STAGES(SYNC), .DEB_LEN(DEB)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_all    (en_all),
      .order_sel (order_sel),
      .reg_en    (reg_en),
      .pg_raw    (pg_raw),
      .tmo_lim   (tmo_lim),
      .rail_en   (rail_en),
      .all_good  (all_good)
   );

   // regulator models and enable-time recorder
   initial begin
      for (int i = 0; i < 3; i++) begin
         dly[i] = 5; cnt[i] = 0; t_on[i] = -1;
      end
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      for (int i = 0; i < 3; i++) begin
         if (rail_en[i]) cnt[i] = cnt[i] + 1;
         else            cnt[i] = 0;
         if (rail_en[i] && !prev_en[i]) t_on[i] = cyc;
      end
      prev_en = rail_en;
   end

   always @* begin
      for (int i = 0; i < 3; i++)
         pg_raw[i] = glitch[i] | (rail_en[i] && (cnt[i] >= dly[i]));
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_track();
      for (int i = 0; i < 3; i++) t_on[i] = -1;
   endtask

   task automatic quiesce();
      en_all = 1'b0; reg_en = 3'b000; glitch = 3'b000;
      for (int i = 0; i < 3; i++) dly[i] = 5;
      tmo_lim = 16'd1000;
      tick(20);
      clear_track();
   endtask

   task automatic test_reset();
      tick(3);
      chk(rail_en == 3'b000, "R1 rail_en", int'(rail_en), 0);
      chk(all_good == 1'b0, "R1 all_good", int'(all_good), 0);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic test_order(input logic [1:0] sel, input int e0, input int e1, input int e2,
                             input string req);
      quiesce();
      order_sel = sel;
      en_all = 1'b1;
      tick(150);
      chk(t_on[e0] > 0 && t_on[e0] < t_on[e1], req, t_on[e0], t_on[e1]);
      chk(t_on[e1] < t_on[e2], req, t_on[e1], t_on[e2]);
      // R5: each step waits for the previous regulator's good
      chk(t_on[e1] - t_on[e0] >= dly[e0] + SYNC, "R5 gap", t_on[e1] - t_on[e0], dly[e0] + SYNC);
      chk(all_good == 1'b1, "R10 all settled", int'(all_good), 1);
      en_all = 1'b0;
      tick(5);
   endtask

   task automatic test_timeout();
      quiesce();
      dly[0] = NEVER;
      tmo_lim = 16'd20;
      order_sel = 2'b00;
      en_all = 1'b1;
      tick(150);
      chk(t_on[1] - t_on[0] == 20, "R6 timeout step", t_on[1] - t_on[0], 20);
      chk(t_on[2] - t_on[1] >= dly[1] + SYNC, "R5 after timeout", t_on[2] - t_on[1], dly[1] + SYNC);
      chk(all_good == 1'b0, "R10 rail not good", int'(all_good), 0);
      en_all = 1'b0;
      tick(5);
   endtask

   task automatic test_latch();
      quiesce();
      order_sel = 2'b00;
      en_all = 1'b1;
      tick(1);
      order_sel = 2'b10;
      tick(150);
      chk(t_on[0] < t_on[1] && t_on[1] < t_on[2], "R7 order kept", t_on[2], -1);
      en_all = 1'b0;
      tick(5);
   endtask

   task automatic test_drop();
      quiesce();
      reg_en = 3'b010;
      order_sel = 2'b00;
      en_all = 1'b1;
      tick(150);
      chk(rail_en == 3'b111, "R8 all up", int'(rail_en), 7);
      en_all = 1'b0;
      #1;
      chk(rail_en == 3'b010, "R8 drop", int'(rail_en), 2);
      reg_en = 3'b000;
      tick(5);
      order_sel = 2'b10;
      en_all = 1'b1;
      tick(1);
      chk(rail_en == 3'b100, "R8 restart first", int'(rail_en), 4);
      en_all = 1'b0;
      tick(5);
   endtask

   task automatic test_reg();
      quiesce();
      reg_en = 3'b101;
      #1;
      chk(rail_en == 3'b101, "R9 reg only", int'(rail_en), 5);
      tick(30);
      chk(all_good == 1'b1, "R10 reg rails good", int'(all_good), 1);
      reg_en = 3'b000;
      #1;
      chk(all_good == 1'b0, "R10 none enabled", int'(all_good), 0);
      tick(5);
   endtask

   task automatic test_busy();
      quiesce();
      reg_en = 3'b111;
      tick(30);
      chk(all_good == 1'b1, "R11 before start", int'(all_good), 1);
      order_sel = 2'b00;
      en_all = 1'b1;
      tick(1);
      chk(all_good == 1'b0, "R11 during run", int'(all_good), 0);
      tick(10);
      chk(all_good == 1'b1, "R11 after run", int'(all_good), 1);
      en_all = 1'b0;
      tick(5);
   endtask

   task automatic test_debounce();
      int highs;
      int first;
      quiesce();
      dly[0] = NEVER;
      reg_en = 3'b001;
      tick(5);
      glitch[0] = 1'b1;
      tick(2);
      glitch[0] = 1'b0;
      highs = 0;
      for (int k = 0; k < 12; k++) begin
         tick(1);
         if (all_good) highs++;
      end
      chk(highs == 0, "R12 short pulse", highs, 0);
      glitch[0] = 1'b1;
      first = 0;
      for (int k = 1; k <= 20; k++) begin
         tick(1);
         if (all_good && first == 0) first = k;
      end
      chk(first == SYNC + DEB, "R12 rise latency", first, SYNC + DEB);
      glitch[0] = 1'b0;
      reg_en = 3'b000;
      tick(5);
   endtask

   initial begin
      test_reset();
      test_order(2'b00, 0, 1, 2, "R2 order");
      test_order(2'b01, 0, 2, 1, "R3 order");
      test_order(2'b10, 2, 0, 1, "R4 order");
      test_order(2'b11, 0, 1, 2, "R4 unused code");
      test_timeout();
      test_latch();
      test_drop();
      test_reg();
      test_busy();
      test_debounce();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule